// File: doc/BRIEF.md
# Phase-Synchronized Up-Down PWM Channel

This block generates two pulse-width-modulated outputs from a triangular time base. An internal counter climbs from zero to a period value and descends back to zero, and two compare values decide where each output toggles on the rising slope and on the falling slope. Compare and period values are held in shadow form: the configuration ports may change at any time, and the block adopts the new values only at the moment the counter sits at zero. The outputs therefore never change shape in the middle of a cycle.

Several channels can be chained. A channel in master mode emits a one-cycle sync pulse whenever its counter is at zero and ignores its own sync input. A channel in slave mode loads a phase value into its counter on each sync pulse and forwards the sync input straight to its sync output. A phase load can make the counter leap over a compare point. The block does not lose that edge: in the cycle after the load, each output takes the level it would have reached had the counter travelled to the new position normally. A latched fault forces both outputs high until it is cleared, and the release waits for a counter zero. An interrupt pulse marks every second rising-slope match of compare B.

Top module: `updown_pwm`

## Requirements
- R1: With period P (P >= 2) the counter runs 0, 1, ..., P, P-1, ..., 1, 0, so successive counter-zero instants are 2P cycles apart.
- R2: Output A goes low after the counter meets compare A on the rising slope and goes high after it meets compare A on the falling slope; the value at P belongs to the falling slope and the value at 0 to the rising slope.
- R3: Output B goes high after the counter meets compare B on the rising slope and goes low after it meets compare B on the falling slope.
- R4: A new compare A or compare B value takes effect only in a cycle where the counter is zero; it then applies to that same cycle.
- R5: A new period value takes effect only in a cycle where the counter is zero; the cycle already under way completes with the old period.
- R6: With is_master high, sync_out is high exactly in the cycles where the counter is zero, and sync_in has no effect on the counter or the outputs.
- R7: With is_master low, sync_out equals sync_in in the same cycle, and a sync_in pulse loads phase_in into the counter, which then counts upward.
- R8: If a loaded phase is at or above the active period, the counter is set to the period and counts downward.
- R9: In the cycle after a phase load, output A equals 1 if the new value is below compare A when rising (at or below when falling), and output B equals 1 if the new value is at or above compare B when rising (above when falling), so a skipped compare point is still honoured.
- R10: A high level on fault0, fault1 or fault_force latches a fault; from the next cycle on both outputs are high while the fault is latched.
- R11: The fault stays latched until fault_clr is sampled high, and is released one cycle after the first counter-zero cycle following that sample.
- R12: irq is a one-cycle pulse, raised in the cycle after every second counter value equal to compare B on the rising slope.
- R13: During reset the outputs and irq are low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_master | input | 1 | 1: master (sync from counter zero), 0: slave (phase load on sync) |
| period_in | input | W | Period value, shadowed |
| cmpa_in | input | W | Compare A value, shadowed |
| cmpb_in | input | W | Compare B value, shadowed |
| phase_in | input | W | Counter value loaded on a slave sync |
| sync_in | input | 1 | Sync pulse from the upstream channel |
| fault0 | input | 1 | Fault source 0 |
| fault1 | input | 1 | Fault source 1 |
| fault_force | input | 1 | Software fault request |
| fault_clr | input | 1 | Request to release a latched fault |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| sync_out | output | 1 | Sync pulse to the downstream channel |
| irq | output | 1 | Interrupt pulse |

## Verification
The hard case is a phase load that lands the counter on the far side of a compare point, in particular when the phase steps downward through compare A or compare B on successive syncs. The bench drives a slave channel with one sync per triangle and sweeps the phase from above the period down to zero and back up in unit steps, then fires syncs at irregular spacing. Each cycle it compares both outputs with a level computed arithmetically from the counter position, so a dropped or stretched pulse at any phase step is seen at once.

// File: rtl/updown_pwm.sv
module updown_pwm #(
  parameter int W         = 16,
  parameter int IRQ_EVERY = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         is_master,
  input  logic [W-1:0] period_in,
  input  logic [W-1:0] cmpa_in,
  input  logic [W-1:0] cmpb_in,
  input  logic [W-1:0] phase_in,
  input  logic         sync_in,
  input  logic         fault0,
  input  logic         fault1,
  input  logic         fault_force,
  input  logic         fault_clr,
  output logic         out_a,
  output logic         out_b,
  output logic         sync_out,
  output logic         irq
);
  localparam int EW = $clog2(IRQ_EVERY + 1);

  logic [W-1:0]  cnt, prd_r, ca_r, cb_r;
  logic          up, qa, qb, trip_lat, clr_pend, irq_r;
  logic [EW-1:0] ev;

  function automatic logic lvl_a(logic [W-1:0] c, logic u, logic [W-1:0] m);
    return u ? (c < m) : (c <= m);
  endfunction

  function automatic logic lvl_b(logic [W-1:0] c, logic u, logic [W-1:0] m);
    return u ? (c >= m) : (c > m);
  endfunction

  wire         at_zero = (cnt == '0);
  wire [W-1:0] prd_e   = at_zero ? period_in : prd_r;
  wire [W-1:0] ca_e    = at_zero ? cmpa_in : ca_r;
  wire [W-1:0] cb_e    = at_zero ? cmpb_in : cb_r;
  wire         load    = !is_master && sync_in;
  wire         ld_down = (phase_in >= prd_e);
  wire [W-1:0] ld_cnt  = ld_down ? prd_e : phase_in;
  wire         top     = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, prd_e};
  wire         ma      = (cnt == ca_e);
  wire         mb      = (cnt == cb_e);
  wire         trip_set = fault0 | fault1 | fault_force;

  assign out_a    = trip_lat | qa;
  assign out_b    = trip_lat | qb;
  assign sync_out = is_master ? at_zero : sync_in;
  assign irq      = irq_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      up       <= 1'b1;
      prd_r    <= '0;
      ca_r     <= '0;
      cb_r     <= '0;
      qa       <= 1'b0;
      qb       <= 1'b0;
      ev       <= '0;
      irq_r    <= 1'b0;
      trip_lat <= 1'b0;
      clr_pend <= 1'b0;
    end else begin
      if (at_zero) begin
        prd_r <= period_in;
        ca_r  <= cmpa_in;
        cb_r  <= cmpb_in;
      end

      if (load) begin
        cnt <= ld_cnt;
        up  <= !ld_down;
        qa  <= lvl_a(ld_cnt, !ld_down, ca_e);
        qb  <= lvl_b(ld_cnt, !ld_down, cb_e);
      end else begin
        if (up) begin
          if (top) begin
            cnt <= prd_e;
            up  <= 1'b0;
          end else begin
            cnt <= cnt + W'(1);
          end
        end else if (cnt <= W'(1)) begin
          cnt <= '0;
          up  <= 1'b1;
        end else begin
          cnt <= cnt - W'(1);
        end
        if (ma) qa <= !up;
        if (mb) qb <= up;
      end

      irq_r <= 1'b0;
      if (mb && up) begin
        if (ev == EW'(IRQ_EVERY - 1)) begin
          ev    <= '0;
          irq_r <= 1'b1;
        end else begin
          ev <= ev + EW'(1);
        end
      end

      if (trip_set) begin
        trip_lat <= 1'b1;
        clr_pend <= 1'b0;
      end else if (clr_pend && at_zero) begin
        trip_lat <= 1'b0;
        clr_pend <= 1'b0;
      end else if (fault_clr && trip_lat) begin
        clr_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/updown_pwm_chk.sv
module updown_pwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         fault0,
  input logic         fault1,
  input logic         fault_force,
  input logic         out_a,
  input logic         out_b,
  input logic         irq,
  input logic [W-1:0] cnt,
  input logic [W-1:0] prd_r,
  input logic [W-1:0] ca_r,
  input logic [W-1:0] cb_r,
  input logic         trip_lat
);
  a_r1_within_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= prd_r);

  a_r4_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ($stable(ca_r) && $stable(cb_r)));

  a_r5_prd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> $stable(prd_r));

  a_r10_fault_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
    (fault0 || fault1 || fault_force) |=> (out_a && out_b));

  a_r11_fault_held: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_lat && cnt != '0) |=> trip_lat);

  a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
endmodule

bind updown_pwm updown_pwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault0(fault0), .fault1(fault1),
  .fault_force(fault_force), .out_a(out_a), .out_b(out_b), .irq(irq),
  .cnt(cnt), .prd_r(prd_r), .ca_r(ca_r), .cb_r(cb_r), .trip_lat(trip_lat)
);

// File: tb/updown_pwm_tb.sv
module updown_pwm_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_master = 1'b1;
  logic [W-1:0] period_in = 16'd20, cmpa_in = 16'd11, cmpb_in = 16'd9, phase_in = '0;
  logic sync_in = 1'b0, fault0 = 1'b0, fault1 = 1'b0, fault_force = 1'b0, fault_clr = 1'b0;
  logic out_a, out_b, sync_out, irq;

  always #4 clk = ~clk;

  updown_pwm #(.W(W), .IRQ_EVERY(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .is_master(is_master), .period_in(period_in),
    .cmpa_in(cmpa_in), .cmpb_in(cmpb_in), .phase_in(phase_in), .sync_in(sync_in),
    .fault0(fault0), .fault1(fault1), .fault_force(fault_force), .fault_clr(fault_clr),
    .out_a(out_a), .out_b(out_b), .sync_out(sync_out), .irq(irq)
  );

  int nchk = 0, nerr = 0, cyc = 0, irq_cnt = 0;
  int zs[$];
  string tag_a = "R2", tag_b = "R3";

  int mc, mprd, mca, mcb, mev;
  bit mup, eA, eB, eIrq, mtrip, mpend;

  function automatic bit la(int c, bit u, int m);
    return u ? (c < m) : (c <= m);
  endfunction
  function automatic bit lb(int c, bit u, int m);
    return u ? (c >= m) : (c > m);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic cycle();
    int pe, ae, be, nc;
    bit z, nu, nIrq;
    #1;
    if (is_master) chk(sync_out === (mc == 0), "R6", sync_out, mc == 0);
    else           chk(sync_out === sync_in, "R7", sync_out, sync_in);
    chk(irq === eIrq, "R12", irq, eIrq);
    if (cyc >= 50) begin
      chk(out_a === (mtrip | eA), tag_a, out_a, mtrip | eA);
      chk(out_b === (mtrip | eB), tag_b, out_b, mtrip | eB);
    end
    if (is_master && sync_out) zs.push_back(cyc);
    if (irq) irq_cnt++;
    z  = (mc == 0);
    pe = z ? int'(period_in) : mprd;
    ae = z ? int'(cmpa_in) : mca;
    be = z ? int'(cmpb_in) : mcb;
    nIrq = 1'b0;
    if (mc == be && mup) begin
      if (mev == 1) begin mev = 0; nIrq = 1'b1; end
      else mev++;
    end
    if (!is_master && sync_in) begin
      if (int'(phase_in) >= pe) begin nc = pe; nu = 1'b0; end
      else begin nc = int'(phase_in); nu = 1'b1; end
      eA = la(nc, nu, ae);
      eB = lb(nc, nu, be);
    end else begin
      eA = la(mc, mup, ae);
      eB = lb(mc, mup, be);
      if (mup) begin
        if (mc + 1 >= pe) begin nc = pe; nu = 1'b0; end
        else begin nc = mc + 1; nu = 1'b1; end
      end else if (mc <= 1) begin nc = 0; nu = 1'b1; end
      else begin nc = mc - 1; nu = 1'b0; end
    end
    if (z) begin mprd = int'(period_in); mca = int'(cmpa_in); mcb = int'(cmpb_in); end
    if (fault0 | fault1 | fault_force) begin mtrip = 1'b1; mpend = 1'b0; end
    else if (mpend && z) begin mtrip = 1'b0; mpend = 1'b0; end
    else if (fault_clr && mtrip) mpend = 1'b1;
    mc = nc; mup = nu; eIrq = nIrq;
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic to_zero();
    int k;
    k = zs.size();
    while (zs.size() == k) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int x, k;
    repeat (3) @(negedge clk);
    #1;
    // R13 reset state
    chk(out_a === 1'b0, "R13", out_a, 0);
    chk(out_b === 1'b0, "R13", out_b, 0);
    chk(irq === 1'b0, "R13", irq, 0);
    chk(sync_out === 1'b1, "R13", sync_out, 1);
    @(negedge clk);
    rst_n = 1'b1;
    mc = 0; mup = 1'b1; mprd = 0; mca = 0; mcb = 0; mev = 0;
    eA = 1'b0; eB = 1'b0; eIrq = 1'b0; mtrip = 1'b0; mpend = 1'b0;

    // R1 / R6: master free run, stray sync_in pulses ignored
    for (int i = 0; i < 130; i++) begin
      sync_in = (i % 7 == 3);
      phase_in = 16'(i % 23);
      cycle();
    end
    sync_in = 1'b0;
    chk(zs.size() >= 4, "R1", zs.size(), 4);
    if (zs.size() >= 4) begin
      chk(zs[0] == 0, "R1", zs[0], 0);
      for (int i = 1; i < 4; i++) chk(zs[i] - zs[i-1] == 40, "R1", zs[i] - zs[i-1], 40);
    end

    // R12: two interrupts over four triangles
    to_zero();
    irq_cnt = 0;
    run(160);
    chk(irq_cnt == 2, "R12", irq_cnt, 2);

    // R5: period change mid-cycle
    to_zero();
    x = zs[zs.size()-1];
    k = zs.size();
    run(5);
    period_in = 16'd12;
    run(100);
    chk(zs.size() >= k + 2, "R5", zs.size() - k, 2);
    if (zs.size() >= k + 2) begin
      chk(zs[k] - x == 40, "R5", zs[k] - x, 40);
      chk(zs[k+1] - zs[k] == 24, "R5", zs[k+1] - zs[k], 24);
    end
    period_in = 16'd20;
    run(60);

    // R4: compare change mid-cycle
    to_zero();
    run(3);
    tag_a = "R4"; tag_b = "R4";
    cmpa_in = 16'd5; cmpb_in = 16'd14;
    run(120);
    cmpa_in = 16'd11; cmpb_in = 16'd9;
    run(90);

    // R7 / R8 / R9: slave phase sweep down then up
    is_master = 1'b0;
    tag_a = "R2"; tag_b = "R3";
    run(45);
    for (int p = 22; p >= 0; p--) begin
      tag_a = (p >= 20) ? "R8" : "R9"; tag_b = tag_a;
      phase_in = 16'(p);
      sync_in = 1'b1; cycle();
      sync_in = 1'b0; run(40);
    end
    for (int p = 1; p <= 22; p++) begin
      tag_a = (p >= 20) ? "R8" : "R9"; tag_b = tag_a;
      phase_in = 16'(p);
      sync_in = 1'b1; cycle();
      sync_in = 1'b0; run(40);
    end
    tag_a = "R9"; tag_b = "R9";
    for (int i = 0; i < 60; i++) begin
      phase_in = 16'((i * 7) % 24);
      sync_in = 1'b1; cycle();
      sync_in = 1'b0; run(3 + (i * 5) % 17);
    end
    sync_in = 1'b1; phase_in = 16'd9; cycle();
    sync_in = 1'b1; phase_in = 16'd9; cycle();
    sync_in = 1'b0; run(45);

    // R10 / R11: each fault source, then clear
    is_master = 1'b1;
    tag_a = "R2"; tag_b = "R3";
    run(45);
    for (int s = 0; s < 3; s++) begin
      tag_a = "R10"; tag_b = "R10";
      fault0 = (s == 0); fault1 = (s == 1); fault_force = (s == 2);
      cycle();
      fault0 = 1'b0; fault1 = 1'b0; fault_force = 1'b0;
      run(15 + 9 * s);
      #1;
      chk(out_a && out_b, "R10", {out_a, out_b}, 3);
      tag_a = "R11"; tag_b = "R11";
      fault_clr = 1'b1; cycle();
      fault_clr = 1'b0;
      #1;
      chk(out_a && out_b, "R11", {out_a, out_b}, 3);
      run(60);
    end

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule